// File: doc/BRIEF.md
# Grouped Interrupt Status Controller

This block gathers one-cycle error event pulses and eight level-sensitive device interrupt lines into one 32-bit status word. Error bits are sticky. Software clears them a whole group at a time, by writing a selector word in which each bit names one group. An enable word masks the status into a single host interrupt output. A fixed set of severe errors drives a separate fatal output, and that output ignores the enable word.

A sticky flag in the top status bit records that a second error arrived while an earlier one was still pending. A routing word assigns a 3-bit device number to each interrupt line so that software can keep that mapping in the block and read it back. All state sits behind a small register port with four word addresses. Writes take effect at the clock edge and reads are combinational.

Top module: `irq_group_ctrl`

## Requirements
- R1: After a synchronous reset every stored bit is zero. Status, enable and routing all read 0, and `host_irq` and `fatal_err` are low.
- R2: The register port has four addresses. Address 0 is status and is read-only, so writes to it have no effect. Address 1 is the 32-bit enable word and can be read and written. Address 2 is the group-clear selector, which acts only on writes and always reads 0. Address 3 is the routing word: 24 bits are stored, they read back in bits 23:0, and bits 31:24 read 0.
- R3: When `err_evt[k]` is high for one cycle, status bit k+8 is set at the next clock edge. The bit then stays set until its group is cleared.
- R4: Status bits 7:0 show `irq_lines` as sampled at the previous clock edge. Group-clear writes never change them.
- R5: Each selector bit clears its own group of status bits. Bit 0 clears bits 15:10 and bit 8. Bit 1 clears bits 16 and 30. Bit 2 clears bits 21:17. Bit 3 clears bits 23, 24, 25 and 27. Bit 4 clears bits 9, 26 and 28. Bit 5 clears bits 22 and 29. Bit 6 clears bit 31.
- R6: Writing 0x7F to the selector clears every status bit from 31 down to 8.
- R7: If an event sets a bit in the same cycle that a clear of its group is written, the bit ends up set.
- R8: Status bit 31 is set in two cases. The first is an event on `err_evt[22:0]` while any of status bits 30:8 is already set. The second is `err_evt[23]`. Several events in one cycle from a clean state do not set bit 31. Only selector bit 6 clears it.
- R9: `host_irq` is high exactly when some status bit is set and its enable bit is also set.
- R10: `fatal_err` is high exactly when any of status bits 13, 14 or 22 to 29 is set, whatever the enable word holds.
- R11: In the routing word, the device number of line n sits in bits 3n+2 down to 3n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Word address: 0 status, 1 enable, 2 clear, 3 routing |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| err_evt | input | 24 | Error event pulses; bit k feeds status bit k+8 |
| irq_lines | input | 8 | Level device interrupt lines |
| host_irq | output | 1 | Enabled-status interrupt request |
| fatal_err | output | 1 | Fatal error indication |

## Verification
On every cycle, the assertions check that error bits survive cycles with no clear write and that each event sets its bit one edge later. They also check that the line bits copy the inputs with one cycle of delay, that a rise of the multiple-error flag or of the fatal output can be traced to a qualifying event, and that a full clear with no events empties the error bits. Some behaviour depends on an exact sequence of writes and events, and only the bench scenarios show it. That covers the membership of each clear group, the rule that a set beats a same-cycle clear, the case where several events arrive together from a clean state, the mapping of fields in the routing word, writes to the read-only status address, and the fatal output staying independent of the enable word.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

    localparam int STAT_W     = 32;
    localparam int LINES      = 8;
    localparam int EVT_W      = STAT_W - LINES;
    localparam int CLR_GROUPS = 7;
    localparam int DEV_W      = 3;
    localparam int ROUTE_W    = LINES * DEV_W;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_CLEAR  = 2'd2,
        SEL_ROUTE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        reg_sel_e          sel;
        logic [STAT_W-1:0] data;
    } reg_req_t;

    // Status-space masks, one per selector bit
    localparam logic [STAT_W-1:0] GROUP_MASK [CLR_GROUPS] = '{
        32'h0000_FD00,   // bus group plus byte-enable error
        32'h4001_0000,   // memory parity / size fault
        32'h003E_0000,   // link errors
        32'h0B80_0000,   // request dispatch
        32'h1400_0200,   // response buffer
        32'h2040_0000,   // overflow / unexpected response
        32'h8000_0000    // multiple-error flag
    };

    localparam logic [STAT_W-1:0] FATAL_MASK = 32'h3FC0_6000;

    function automatic logic [EVT_W-1:0] err_clear_mask(input logic [CLR_GROUPS-1:0] sel);
        logic [STAT_W-1:0] m;
        m = '0;
        for (int g = 0; g < CLR_GROUPS; g++) begin
            if (sel[g]) m = m | GROUP_MASK[g];
        end
        return m[STAT_W-1:LINES];
    endfunction

endpackage

// File: rtl/irqs_sticky.sv
module irqs_sticky
    import irqs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [EVT_W-1:0]      evt,
    input  logic                  clr_stb,
    input  logic [CLR_GROUPS-1:0] clr_sel,
    input  logic [LINES-1:0]      lines,
    output logic [STAT_W-1:0]     status
);
    localparam int MULTI = EVT_W - 1;

    logic [EVT_W-1:0] err_q;
    logic [EVT_W-1:0] clr_vec;
    logic [LINES-1:0] lines_q;
    logic             prior_err;
    logic             new_err;

    assign clr_vec   = clr_stb ? err_clear_mask(clr_sel) : '0;
    assign prior_err = |err_q[MULTI-1:0];
    assign new_err   = |evt[MULTI-1:0];

    for (genvar b = 0; b < MULTI; b++) begin : g_err
        always_ff @(posedge clk) begin
            if (rst)
                err_q[b] <= 1'b0;
            else
                err_q[b] <= (err_q[b] & ~clr_vec[b]) | evt[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            err_q[MULTI] <= 1'b0;
        else
            err_q[MULTI] <= (err_q[MULTI] & ~clr_vec[MULTI]) | evt[MULTI]
                            | (new_err & prior_err);
    end

    always_ff @(posedge clk) begin
        if (rst) lines_q <= '0;
        else     lines_q <= lines;
    end

    assign status = {err_q, lines_q};

endmodule

// File: rtl/irqs_cfg.sv
module irqs_cfg
    import irqs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en_wr,
    input  logic               route_wr,
    input  logic [STAT_W-1:0]  wdata,
    output logic [STAT_W-1:0]  enable,
    output logic [ROUTE_W-1:0] route
);
    always_ff @(posedge clk) begin
        if (rst)        enable <= '0;
        else if (en_wr) enable <= wdata;
    end

    for (genvar n = 0; n < LINES; n++) begin : g_route
        always_ff @(posedge clk) begin
            if (rst)
                route[n*DEV_W +: DEV_W] <= '0;
            else if (route_wr)
                route[n*DEV_W +: DEV_W] <= wdata[n*DEV_W +: DEV_W];
        end
    end

endmodule

// File: rtl/irqs_outs.sv
module irqs_outs
    import irqs_pkg::*;
(
    input  logic [STAT_W-1:0] status,
    input  logic [STAT_W-1:0] enable,
    output logic              host_irq,
    output logic              fatal_err
);
    assign host_irq  = |(status & enable);
    assign fatal_err = |(status & FATAL_MASK);
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
    import irqs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [23:0] err_evt,
    input  logic [7:0]  irq_lines,
    output logic        host_irq,
    output logic        fatal_err
);
    reg_req_t           req;
    logic [STAT_W-1:0]  status_w;
    logic [STAT_W-1:0]  enable_w;
    logic [ROUTE_W-1:0] route_w;

    assign req.wr   = reg_wr;
    assign req.sel  = reg_sel_e'(reg_addr);
    assign req.data = reg_wdata;

    irqs_sticky u_sticky (
        .clk     (clk),
        .rst     (rst),
        .evt     (err_evt),
        .clr_stb (req.wr && req.sel == SEL_CLEAR),
        .clr_sel (req.data[CLR_GROUPS-1:0]),
        .lines   (irq_lines),
        .status  (status_w)
    );

    irqs_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .en_wr    (req.wr && req.sel == SEL_ENABLE),
        .route_wr (req.wr && req.sel == SEL_ROUTE),
        .wdata    (req.data),
        .enable   (enable_w),
        .route    (route_w)
    );

    irqs_outs u_outs (
        .status    (status_w),
        .enable    (enable_w),
        .host_irq  (host_irq),
        .fatal_err (fatal_err)
    );

    always_comb begin
        unique case (req.sel)
            SEL_STATUS: reg_rdata = status_w;
            SEL_ENABLE: reg_rdata = enable_w;
            SEL_CLEAR:  reg_rdata = '0;
            SEL_ROUTE:  reg_rdata = {{(STAT_W-ROUTE_W){1'b0}}, route_w};
        endcase
    end

endmodule

// File: rtl/irqs_chk.sv
module irqs_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [23:0] err_evt,
    input logic [7:0]  irq_lines,
    input logic [31:0] status,
    input logic        fatal_err
);
    logic clr_wr;
    assign clr_wr = reg_wr && reg_addr == 2'd2;

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> ((status[31:8] & $past(status[31:8])) == $past(status[31:8])));

    // R3
    event_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (err_evt != 24'h0) |=> ((status[31:8] & $past(err_evt)) == $past(err_evt)));

    // R4
    line_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (status[7:0] == $past(irq_lines)));

    // R8
    multi_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[31]) |-> ($past(err_evt[23]) ||
                               ($past(err_evt[22:0]) != 23'h0 && $past(status[30:8]) != 23'h0)));

    // R10
    fatal_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fatal_err) |-> (($past(err_evt) & 24'h3FC060) != 24'h0));

    // R6
    clear_all_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && reg_wdata[6:0] == 7'h7F && err_evt == 24'h0) |=> (status[31:8] == 24'h0));

endmodule

bind irq_group_ctrl irqs_chk u_irqs_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .err_evt   (err_evt),
    .irq_lines (irq_lines),
    .status    (status_w),
    .fatal_err (fatal_err)
);

// File: tb/test_irq_group_ctrl.sv
module test_irq_group_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [23:0] err_evt = '0;
    logic [7:0]  irq_lines = '0;
    logic        host_irq;
    logic        fatal_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [23:0] FATAL_HI = 24'h3FC060; // R10 in err-bit space

    typedef struct packed {
        logic [23:0] evt;
        logic [6:0]  clr;
        logic [23:0] exp_hi;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{24'h000001, 7'h00, 24'h000001},   // R3
        '{24'h000002, 7'h00, 24'h800003},   // R8 second error
        '{24'h000000, 7'h01, 24'h800002},   // R5 bus group
        '{24'h000000, 7'h10, 24'h800000},   // R5 response group
        '{24'h000000, 7'h40, 24'h000000},   // R8 cleared by bit 6
        '{24'h003E00, 7'h00, 24'h003E00},   // R8 simultaneous, no flag
        '{24'h000000, 7'h04, 24'h000000},   // R5 link group
        '{24'h400100, 7'h00, 24'h400100},   // R3
        '{24'h0B8000, 7'h02, 24'h8B8000},   // R5 memory group
        '{24'h204000, 7'h08, 24'hA04000},   // R5 dispatch group
        '{24'h000000, 7'h20, 24'h800000},   // R5 group 5
        '{24'h000000, 7'h7F, 24'h000000}    // R6
    };

    irq_group_ctrl i_irq_group_ctrl (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .err_evt   (err_evt),
        .irq_lines (irq_lines),
        .host_irq  (host_irq),
        .fatal_err (fatal_err)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [23:0] e);
        @(negedge clk);
        err_evt = e;
        @(negedge clk);
        err_evt = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_reg(2'd0, d); check(d == 32'h0, "R1 status", d, 32'h0);
        rd_reg(2'd1, d); check(d == 32'h0, "R1 enable", d, 32'h0);
        rd_reg(2'd3, d); check(d == 32'h0, "R1 route", d, 32'h0);
        check({host_irq, fatal_err} == 2'b00, "R1 outputs", {30'h0, host_irq, fatal_err}, 32'h0);

        // table walk: R3 R5 R6 R8 R10
        for (int i = 0; i < 12; i++) begin
            if (VECS[i].evt != '0) pulse(VECS[i].evt);
            if (VECS[i].clr != '0) wr_reg(2'd2, {25'h0, VECS[i].clr});
            rd_reg(2'd0, d);
            check(d[31:8] == VECS[i].exp_hi, "R5 table status", {8'h0, d[31:8]}, {8'h0, VECS[i].exp_hi});
            check(fatal_err == |(VECS[i].exp_hi & FATAL_HI), "R10 table fatal",
                  {31'h0, fatal_err}, {31'h0, |(VECS[i].exp_hi & FATAL_HI)});
        end

        // R4 lines follow with one cycle delay, immune to clear
        @(negedge clk); irq_lines = 8'hA5;
        rd_reg(2'd0, d); check(d[7:0] == 8'h00, "R4 before edge", {24'h0, d[7:0]}, 32'h0);
        @(negedge clk);
        rd_reg(2'd0, d); check(d[7:0] == 8'hA5, "R4 lines", {24'h0, d[7:0]}, 32'hA5);
        check(host_irq == 1'b0, "R9 nothing enabled", {31'h0, host_irq}, 32'h0);
        wr_reg(2'd2, 32'h7F);
        rd_reg(2'd0, d); check(d[7:0] == 8'hA5, "R4 clear ignored", {24'h0, d[7:0]}, 32'hA5);

        // R9 enable a live line
        wr_reg(2'd1, 32'h0000_0004);
        rd_reg(2'd1, d); check(d == 32'h4, "R2 enable readback", d, 32'h4);
        check(host_irq == 1'b1, "R9 line enabled", {31'h0, host_irq}, 32'h1);
        @(negedge clk); irq_lines = 8'h00;
        @(negedge clk);
        check(host_irq == 1'b0, "R9 line dropped", {31'h0, host_irq}, 32'h0);

        // R10 fatal with enable cleared; R9 no host irq
        wr_reg(2'd1, 32'h0);
        pulse(24'h000020);   // status bit 13
        check(fatal_err == 1'b1, "R10 fatal unmasked", {31'h0, fatal_err}, 32'h1);
        check(host_irq == 1'b0, "R9 disabled error", {31'h0, host_irq}, 32'h0);
        wr_reg(2'd1, 32'h0000_2000);
        check(host_irq == 1'b1, "R9 error enabled", {31'h0, host_irq}, 32'h1);
        wr_reg(2'd2, 32'h01);
        check(fatal_err == 1'b0, "R10 fatal cleared", {31'h0, fatal_err}, 32'h0);

        // R7 set and clear in same cycle
        @(negedge clk);
        err_evt = 24'h000008; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h01;
        @(negedge clk);
        err_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd_reg(2'd0, d); check(d[11] == 1'b1, "R7 set wins", d, 32'h800);

        // R2 status address is read-only
        wr_reg(2'd0, 32'hFFFF_FFFF);
        rd_reg(2'd0, d); check(d == 32'h0000_0800, "R2 status write ignored", d, 32'h800);
        rd_reg(2'd2, d); check(d == 32'h0, "R2 clear reads zero", d, 32'h0);

        // R11 routing fields
        wr_reg(2'd3, 32'hFFFA_C688);
        rd_reg(2'd3, d); check(d == 32'h00FA_C688, "R11 route readback", d, 32'h00FAC688);
        check(d[5:3] == 3'd1 && d[23:21] == 3'd7, "R11 line fields",
              {26'h0, d[23:21], d[5:3]}, {26'h0, 3'd7, 3'd1});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule